// File: doc/BRIEF.md
# Expansion Register File with Multiplier

This block is the CPU-facing register set of an advanced cartridge controller. It sits on an 8-bit data bus with a 16-bit address and decodes a small group of write registers. These set the program and character bank sizes, two write-protect codes, a graphics mode, and a nametable source for each of the four screen quadrants. The group also includes a fill tile and a fill attribute, plus the interrupt enable and interrupt line. Every register value goes out on dedicated outputs to the rest of the controller.

Three locations act differently on a read. The two multiplier operand addresses return the low and high bytes of the unsigned 16-bit product of the stored operands. The interrupt status address returns the pending scanline flag and clears it. A 1 KB expansion RAM window can always be read, but it only accepts writes in some graphics modes. Any other read returns the upper byte of the bus address, so write-only registers read back as open-bus style data.

Top module: `exp_regfile`

## Requirements
- R1: A write to 0x5205 stores operand A and a write to 0x5206 stores operand B. A read of 0x5205 returns bits 7:0 of the unsigned product A×B, and a read of 0x5206 returns bits 15:8. A read in the cycle after an operand write already sees the new product.
- R2: A one-cycle pulse on `line_hit` sets bit 7 of the status register. A read of 0x5204 returns the status byte and clears it for the following cycle. When `line_hit` and that read happen in the same cycle, the read returns the old value and bit 7 is left set.
- R3: Register 0x5105 holds four 2-bit codes, where bits 1:0 belong to quadrant 0 and bits 7:6 to quadrant 3. For each quadrant q:
  - code 0 drives all of `quad_page[q]`, `quad_xram[q]` and `quad_fill[q]` to 0;
  - code 1 sets `quad_page[q]`;
  - code 2 sets `quad_xram[q]`;
  - code 3 sets `quad_fill[q]`.
- R4: Each of the five control registers keeps only bits 1:0 of the written byte and drives them on its output. The registers are program size (0x5100), character size (0x5101), protect A (0x5102), protect B (0x5103) and graphics mode (0x5104).
- R5: A write to 0x5106 stores the whole byte as `fill_tile`. A write to 0x5107 keeps bits 1:0 and drives them into all four 2-bit positions of `fill_attr`.
- R6: Writes to 0x5C00–0x5FFF store into the expansion RAM only when the graphics mode is 0 or 2; in modes 1 and 3 they leave it unchanged. Reads of that window return the stored byte in every mode.
- R7: A read of any address other than 0x5204, 0x5205, 0x5206 and the RAM window returns bits 15:8 of the address. This includes the write-only registers.
- R8: After reset, program size and character size are 3. The graphics mode, interrupt enable, interrupt line and status are 0, and so are all other registers.
- R9: A write to 0x5204 stores the interrupt enable byte without changing the status. A write to 0x5203 stores the interrupt line byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, qualifies the clear-on-read side effect |
| bus_rdata | output | 8 | Combinational read data |
| line_hit | input | 1 | Scanline match pulse that sets the pending flag |
| prg_size | output | 2 | Program bank size code |
| chr_size | output | 2 | Character bank size code |
| prot_a | output | 2 | First write-protect code |
| prot_b | output | 2 | Second write-protect code |
| gfx_mode | output | 2 | Graphics mode |
| quad_page | output | 4 | Per quadrant: internal page 1 selected |
| quad_xram | output | 4 | Per quadrant: expansion RAM selected |
| quad_fill | output | 4 | Per quadrant: fill nametable selected |
| fill_tile | output | 8 | Fill tile number |
| fill_attr | output | 8 | Replicated fill attribute |
| irq_enable | output | 8 | Interrupt enable byte |
| irq_line | output | 8 | Interrupt line byte |

## Verification
**Status flag.** A status flag that is stuck or cleared at the wrong time appears on the second of two back-to-back status reads, one cycle after the first.

**Decode.** A wrong decode shows at once: either a write-only register reads back as something other than the address high byte, or a register output moves on a write aimed at a neighbour.

**Expansion RAM gate.** A corrupt mode gate on the RAM is exposed by writing in a locked mode and reading the same location back. A stale or corrupt operand shows in the product read on the very next cycle.

// File: rtl/exp_regfile_pkg.sv
package exp_regfile_pkg;

    localparam int DW     = 8;
    localparam int AW     = 16;
    localparam int CW     = 2;
    localparam int QUADS  = 4;
    localparam int XAW    = 10;

    localparam logic [AW-1:0] ADR_PRG   = 16'h5100;
    localparam logic [AW-1:0] ADR_CHR   = 16'h5101;
    localparam logic [AW-1:0] ADR_PRA   = 16'h5102;
    localparam logic [AW-1:0] ADR_PRB   = 16'h5103;
    localparam logic [AW-1:0] ADR_GFX   = 16'h5104;
    localparam logic [AW-1:0] ADR_NTMAP = 16'h5105;
    localparam logic [AW-1:0] ADR_FTILE = 16'h5106;
    localparam logic [AW-1:0] ADR_FATTR = 16'h5107;
    localparam logic [AW-1:0] ADR_LINE  = 16'h5203;
    localparam logic [AW-1:0] ADR_STAT  = 16'h5204;
    localparam logic [AW-1:0] ADR_MULA  = 16'h5205;
    localparam logic [AW-1:0] ADR_MULB  = 16'h5206;
    localparam logic [AW-1:0] XRAM_LO   = 16'h5C00;
    localparam logic [AW-1:0] XRAM_HI   = 16'h5FFF;

    localparam logic [DW-1:0] STAT_PEND = 8'h80;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_PRG, SEL_CHR, SEL_PRA, SEL_PRB, SEL_GFX,
        SEL_NTMAP, SEL_FTILE, SEL_FATTR, SEL_LINE, SEL_STAT,
        SEL_MULA, SEL_MULB, SEL_XRAM
    } reg_sel_e;

    typedef enum logic [CW-1:0] {
        NT_PAGE0 = 2'd0,
        NT_PAGE1 = 2'd1,
        NT_XRAM  = 2'd2,
        NT_FILL  = 2'd3
    } nt_src_e;

    typedef struct packed {
        logic [CW-1:0] prg;
        logic [CW-1:0] chr;
        logic [CW-1:0] pra;
        logic [CW-1:0] prb;
        logic [CW-1:0] gfx;
        logic [DW-1:0] ntmap;
        logic [DW-1:0] ftile;
        logic [DW-1:0] fattr;
        logic [DW-1:0] irq_en;
        logic [DW-1:0] irq_line;
        logic [DW-1:0] opa;
        logic [DW-1:0] opb;
    } ctl_t;

    function automatic logic [DW-1:0] spread_attr(input logic [CW-1:0] v);
        return {(DW/CW){v}};
    endfunction

    function automatic logic xram_writable(input logic [CW-1:0] mode);
        return (mode == 2'd0) || (mode == 2'd2);
    endfunction

    function automatic ctl_t ctl_reset();
        ctl_t c;
        c     = '0;
        c.prg = 2'd3;
        c.chr = 2'd3;
        return c;
    endfunction

endpackage

// File: rtl/exp_regfile_dec.sv
module exp_regfile_dec
    import exp_regfile_pkg::*;
(
    input  logic [AW-1:0]  addr,
    output reg_sel_e       sel,
    output logic [XAW-1:0] xidx
);

    always_comb begin
        xidx = addr[XAW-1:0];
        if (addr >= XRAM_LO && addr <= XRAM_HI) begin
            sel = SEL_XRAM;
        end else begin
            case (addr)
                ADR_PRG:   sel = SEL_PRG;
                ADR_CHR:   sel = SEL_CHR;
                ADR_PRA:   sel = SEL_PRA;
                ADR_PRB:   sel = SEL_PRB;
                ADR_GFX:   sel = SEL_GFX;
                ADR_NTMAP: sel = SEL_NTMAP;
                ADR_FTILE: sel = SEL_FTILE;
                ADR_FATTR: sel = SEL_FATTR;
                ADR_LINE:  sel = SEL_LINE;
                ADR_STAT:  sel = SEL_STAT;
                ADR_MULA:  sel = SEL_MULA;
                ADR_MULB:  sel = SEL_MULB;
                default:   sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/exp_regfile_mul.sv
module exp_regfile_mul #(
    parameter int W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);

    localparam int PW = 2 * W;

    always_comb begin
        prod = PW'(a) * PW'(b);
    end

endmodule

// File: rtl/exp_regfile_xram.sv
module exp_regfile_xram #(
    parameter int AWID = 10,
    parameter int DWID = 8,
    parameter int MW   = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_req,
    input  logic [MW-1:0]   mode,
    input  logic [AWID-1:0] idx,
    input  logic [DWID-1:0] wdata,
    output logic [DWID-1:0] rdata
);

    localparam int DEPTH = 1 << AWID;

    logic [DWID-1:0] mem [DEPTH];
    logic            wr_ok;

    assign wr_ok = wr_req && exp_regfile_pkg::xram_writable(mode);

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];

    p_locked_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_req && (mode == 2'd1 || mode == 2'd3)) |=> (mem[$past(idx)] == $past(mem[idx])))
        else $error("R6: locked mode write altered expansion RAM");

    p_open_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_req && (mode == 2'd0 || mode == 2'd2)) |=> (mem[$past(idx)] == $past(wdata)))
        else $error("R6: open mode write not stored");

endmodule

// File: rtl/exp_regfile.sv
module exp_regfile
    import exp_regfile_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [15:0]   bus_addr,
    input  logic [7:0]    bus_wdata,
    input  logic          bus_wr,
    input  logic          bus_rd,
    output logic [7:0]    bus_rdata,
    input  logic          line_hit,
    output logic [1:0]    prg_size,
    output logic [1:0]    chr_size,
    output logic [1:0]    prot_a,
    output logic [1:0]    prot_b,
    output logic [1:0]    gfx_mode,
    output logic [3:0]    quad_page,
    output logic [3:0]    quad_xram,
    output logic [3:0]    quad_fill,
    output logic [7:0]    fill_tile,
    output logic [7:0]    fill_attr,
    output logic [7:0]    irq_enable,
    output logic [7:0]    irq_line
);

    reg_sel_e         sel;
    logic [XAW-1:0]   xidx;
    logic [2*DW-1:0]  prod;
    logic [DW-1:0]    xram_q;
    ctl_t             ctl;
    logic [DW-1:0]    status_q;
    logic             rd_stat;

    exp_regfile_dec u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .xidx (xidx)
    );

    exp_regfile_mul #(.W(DW)) u_mul (
        .a    (ctl.opa),
        .b    (ctl.opb),
        .prod (prod)
    );

    exp_regfile_xram #(.AWID(XAW), .DWID(DW), .MW(CW)) u_xram (
        .clk    (clk),
        .rst    (rst),
        .wr_req (bus_wr && sel == SEL_XRAM),
        .mode   (ctl.gfx),
        .idx    (xidx),
        .wdata  (bus_wdata),
        .rdata  (xram_q)
    );

    // register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= ctl_reset();
        end else if (bus_wr) begin
            case (sel)
                SEL_PRG:   ctl.prg      <= bus_wdata[CW-1:0];
                SEL_CHR:   ctl.chr      <= bus_wdata[CW-1:0];
                SEL_PRA:   ctl.pra      <= bus_wdata[CW-1:0];
                SEL_PRB:   ctl.prb      <= bus_wdata[CW-1:0];
                SEL_GFX:   ctl.gfx      <= bus_wdata[CW-1:0];
                SEL_NTMAP: ctl.ntmap    <= bus_wdata;
                SEL_FTILE: ctl.ftile    <= bus_wdata;
                SEL_FATTR: ctl.fattr    <= spread_attr(bus_wdata[CW-1:0]);
                SEL_LINE:  ctl.irq_line <= bus_wdata;
                SEL_STAT:  ctl.irq_en   <= bus_wdata;
                SEL_MULA:  ctl.opa      <= bus_wdata;
                SEL_MULB:  ctl.opb      <= bus_wdata;
                default:   ;
            endcase
        end
    end

    // pending flag: an event wins over a simultaneous clearing read
    assign rd_stat = bus_rd && (sel == SEL_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else if (line_hit) begin
            status_q <= status_q | STAT_PEND;
        end else if (rd_stat) begin
            status_q <= '0;
        end
    end

    // read mux
    always_comb begin
        case (sel)
            SEL_STAT: bus_rdata = status_q;
            SEL_MULA: bus_rdata = prod[DW-1:0];
            SEL_MULB: bus_rdata = prod[2*DW-1:DW];
            SEL_XRAM: bus_rdata = xram_q;
            default:  bus_rdata = bus_addr[AW-1:AW-DW];
        endcase
    end

    // per-quadrant source decode
    for (genvar q = 0; q < QUADS; q++) begin : g_quad
        nt_src_e code;
        assign code         = nt_src_e'(ctl.ntmap[CW*q +: CW]);
        assign quad_page[q] = (code == NT_PAGE1);
        assign quad_xram[q] = (code == NT_XRAM);
        assign quad_fill[q] = (code == NT_FILL);
    end

    assign prg_size   = ctl.prg;
    assign chr_size   = ctl.chr;
    assign prot_a     = ctl.pra;
    assign prot_b     = ctl.prb;
    assign gfx_mode   = ctl.gfx;
    assign fill_tile  = ctl.ftile;
    assign fill_attr  = ctl.fattr;
    assign irq_enable = ctl.irq_en;
    assign irq_line   = ctl.irq_line;

    // assertions
    p_prod_lo_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADR_MULA) |->
            (bus_rdata == 8'(({8'd0, ctl.opa} * {8'd0, ctl.opb}))))
        else $error("R1: product low byte mismatch");

    p_prod_hi_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADR_MULB) |->
            (bus_rdata == 8'((({8'd0, ctl.opa} * {8'd0, ctl.opb})) >> 8)))
        else $error("R1: product high byte mismatch");

    p_stat_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADR_STAT && !line_hit) |=> (status_q == '0))
        else $error("R2: status not cleared by read");

    p_stat_set_r2: assert property (@(posedge clk) disable iff (rst)
        line_hit |=> status_q[DW-1])
        else $error("R2: pending flag not set");

    p_gfx_mask_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADR_GFX) |=> (gfx_mode == $past(bus_wdata[1:0])))
        else $error("R4: mode register mask");

    p_attr_rep_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADR_FATTR) |=> (fill_attr == {4{$past(bus_wdata[1:0])}}))
        else $error("R5: attribute replication");

    p_unmapped_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 16'h5100 || bus_addr == 16'h6000) |-> (bus_rdata == bus_addr[15:8]))
        else $error("R7: unmapped read data");

    p_reset_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (prg_size == 2'd3 && chr_size == 2'd3 && gfx_mode == 2'd0 &&
                        irq_enable == 8'd0 && irq_line == 8'd0 && status_q == 8'd0))
        else $error("R8: reset values");

    p_en_keeps_stat_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADR_STAT && !line_hit && !bus_rd) |=> $stable(status_q))
        else $error("R9: enable write touched status");

endmodule

// File: tb/exp_regfile_bench.sv
`timescale 1ns/1ps
module exp_regfile_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        line_hit = 1'b0;
    logic [1:0]  prg_size, chr_size, prot_a, prot_b, gfx_mode;
    logic [3:0]  quad_page, quad_xram, quad_fill;
    logic [7:0]  fill_tile, fill_attr, irq_enable, irq_line;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [7:0]  exp_q[$];
    string       req_q[$];
    logic [15:0] adr_q[$];

    always #4 clk = ~clk;

    exp_regfile u_exp_regfile (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .line_hit(line_hit),
        .prg_size(prg_size), .chr_size(chr_size), .prot_a(prot_a), .prot_b(prot_b),
        .gfx_mode(gfx_mode), .quad_page(quad_page), .quad_xram(quad_xram),
        .quad_fill(quad_fill), .fill_tile(fill_tile), .fill_attr(fill_attr),
        .irq_enable(irq_enable), .irq_line(irq_line)
    );

    // monitor: pops one expected item per read cycle
    logic [7:0]  m_exp;
    string       m_req;
    logic [15:0] m_adr;
    always @(negedge clk) begin
        if (bus_rd) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL scoreboard empty: actual=%02h expected=none", bus_rdata);
            end else begin
                m_exp = exp_q.pop_front();
                m_req = req_q.pop_front();
                m_adr = adr_q.pop_front();
                if (bus_rdata !== m_exp) begin
                    bad++;
                    $display("FAIL %s read %04h: actual=%02h expected=%02h",
                             m_req, m_adr, bus_rdata, m_exp);
                end
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] e, input string r,
                      input logic hit = 1'b0);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1; line_hit = hit;
        exp_q.push_back(e); req_q.push_back(r); adr_q.push_back(a);
        @(posedge clk); #1;
        bus_rd = 1'b0; line_hit = 1'b0;
    endtask

    task automatic pulse_hit();
        @(posedge clk); #1;
        line_hit = 1'b1;
        @(posedge clk); #1;
        line_hit = 1'b0;
    endtask

    task automatic chk(input logic [7:0] got, input logic [7:0] e, input string r);
        total++;
        if (got !== e) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", r, got, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R8 reset state
        chk({6'd0, prg_size}, 8'd3, "R8 prg_size");
        chk({6'd0, chr_size}, 8'd3, "R8 chr_size");
        chk({6'd0, gfx_mode}, 8'd0, "R8 gfx_mode");
        chk(irq_enable, 8'd0, "R8 irq_enable");
        chk(irq_line, 8'd0, "R8 irq_line");
        rd(16'h5204, 8'h00, "R8 status");

        // R7 unmapped and write-only reads
        rd(16'h5100, 8'h51, "R7");
        rd(16'h1234, 8'h12, "R7");
        rd(16'h5BFF, 8'h5B, "R7");
        rd(16'h6000, 8'h60, "R7");
        rd(16'h5107, 8'h51, "R7");

        // R4 masks
        wr(16'h5100, 8'hFD); chk({6'd0, prg_size}, 8'd1, "R4 prg");
        wr(16'h5101, 8'h06); chk({6'd0, chr_size}, 8'd2, "R4 chr");
        wr(16'h5102, 8'hAB); chk({6'd0, prot_a}, 8'd3, "R4 prot_a");
        wr(16'h5103, 8'h7C); chk({6'd0, prot_b}, 8'd0, "R4 prot_b");
        wr(16'h5104, 8'hF1); chk({6'd0, gfx_mode}, 8'd1, "R4 gfx");
        chk({6'd0, prg_size}, 8'd1, "R4 prg untouched by neighbour");

        // R5 fill registers
        wr(16'h5106, 8'hC7); chk(fill_tile, 8'hC7, "R5 tile");
        wr(16'h5107, 8'hFE); chk(fill_attr, 8'hAA, "R5 attr");
        wr(16'h5107, 8'h01); chk(fill_attr, 8'h55, "R5 attr");

        // R3 quadrant codes
        wr(16'h5105, 8'hE4);
        chk({4'd0, quad_page}, 8'h02, "R3 page E4");
        chk({4'd0, quad_xram}, 8'h04, "R3 xram E4");
        chk({4'd0, quad_fill}, 8'h08, "R3 fill E4");
        wr(16'h5105, 8'h1B);
        chk({4'd0, quad_page}, 8'h04, "R3 page 1B");
        chk({4'd0, quad_xram}, 8'h02, "R3 xram 1B");
        chk({4'd0, quad_fill}, 8'h01, "R3 fill 1B");

        // R1 multiplier
        wr(16'h5205, 8'd12);
        wr(16'h5206, 8'd13);
        rd(16'h5205, 8'h9C, "R1 lo");
        rd(16'h5206, 8'h00, "R1 hi");
        wr(16'h5205, 8'hFF);
        wr(16'h5206, 8'hFF);
        rd(16'h5205, 8'h01, "R1 lo max");
        rd(16'h5206, 8'hFE, "R1 hi max");
        wr(16'h5205, 8'h00);
        rd(16'h5206, 8'h00, "R1 zero operand");

        // R2 status
        pulse_hit();
        rd(16'h5204, 8'h80, "R2 set");
        rd(16'h5204, 8'h00, "R2 cleared");
        rd(16'h5204, 8'h00, "R2 read with event", 1'b1);
        rd(16'h5204, 8'h80, "R2 event wins");
        rd(16'h5204, 8'h00, "R2 cleared again");

        // R9 enable and line
        pulse_hit();
        wr(16'h5204, 8'hFF); chk(irq_enable, 8'hFF, "R9 enable");
        rd(16'h5204, 8'h80, "R9 status kept");
        wr(16'h5203, 8'h5A); chk(irq_line, 8'h5A, "R9 line");

        // R6 expansion RAM gate
        wr(16'h5104, 8'h00);
        wr(16'h5C10, 8'h11);
        rd(16'h5C10, 8'h11, "R6 mode0 store");
        wr(16'h5104, 8'h01);
        wr(16'h5C10, 8'h22);
        rd(16'h5C10, 8'h11, "R6 mode1 ignored");
        wr(16'h5104, 8'h03);
        wr(16'h5C10, 8'h33);
        rd(16'h5C10, 8'h11, "R6 mode3 ignored");
        wr(16'h5104, 8'h02);
        wr(16'h5FFF, 8'h44);
        rd(16'h5FFF, 8'h44, "R6 mode2 store top");
        wr(16'h5C00, 8'h55);
        rd(16'h5C00, 8'h55, "R6 mode2 store base");

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard leftover: actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule